// File: doc/BRIEF.md
# Capture/Compare Timer with Prescaler

This block is a 32-bit up-counter with one capture/compare channel. It sits on a simple word-addressed register port. The counter advances only on a single-cycle enable and never on a derived clock. That enable comes from one of two sources. The first is the system clock, taken either directly or through a fixed divide-by-16 stage. The second is the rising edge of an external count pin, which first passes through a two-flop synchronizer. Whichever source is chosen then feeds a programmable 8-bit prescaler. A prescale value of N gives one counter step every N+1 source ticks.

The channel has two modes. In capture mode it latches the counter when the capture pin shows a selected edge: rising, falling or both. In compare mode it watches for the counter reaching a reference value. On a match it can restart the counter from zero, and it can toggle or pulse an output pin. Every event sets a sticky flag. The flag is steered to an interrupt line, or to a DMA request that is held until the DMA engine acknowledges it.

Two state machines carry the behaviour. The channel machine has three states. `CH_OFF` is entered whenever the run bit is clear. `CH_CAPTURE` is entered when the timer is running in capture mode. `CH_COMPARE` is entered when the timer is running in compare mode. The machine moves OFF→CAPTURE or OFF→COMPARE when run is set, CAPTURE↔COMPARE when the mode bit changes, and back to OFF from either when run is cleared. The event machine has two states. It moves `EV_IDLE`→`EV_DMA_WAIT` on an event while DMA steering is on, and `EV_DMA_WAIT`→`EV_IDLE` on an acknowledge that does not coincide with a new event.

Top module: `cct_timer`

Register map (word addresses): 0 = CONFIG, 1 = REFERENCE, 2 = COUNT (read/write), 3 = CAPTURED (read only), 4 = STATUS (bit 0 = event flag). CONFIG fields: bit0 run, bit1 external source, bit2 divide-by-16, bit3 compare mode, bits5:4 capture edge (00 none, 01 rising, 10 falling, 11 both), bit6 restart on match, bits8:7 output action (00 low, 01 toggle, 10 one-cycle pulse), bit9 interrupt enable, bit10 DMA steering, bits23:16 prescale.

## Requirements
- R1: After reset, COUNT, CAPTURED and STATUS read 0, and `irq`, `dma_req` and `cmp_out` are low.
- R2: With the system clock source (CONFIG bit1=0, bit2=0) and prescale N, COUNT increases by one every N+1 clock cycles while run is set.
- R3: With CONFIG bit2=1, the system clock is first divided by 16, so COUNT increases once every 16·(N+1) cycles.
- R4: With CONFIG bit1=1, each rising edge of `ext_clk_pin`, after two-flop synchronization, is one source tick; edges arriving while run is clear do not advance COUNT.
- R5: While run is clear COUNT holds its value; a write to COUNT loads it at any time and takes priority over counting.
- R6: In capture mode, a capture-pin edge matching the edge select (01 rising, 10 falling, 11 both) copies COUNT into CAPTURED two cycles after the pin change and sets the flag; non-selected edges change neither CAPTURED nor the flag.
- R7: In compare mode, a counter step taken while COUNT equals REFERENCE is a match that sets the flag; with CONFIG bit6=1 the counter goes to 0 instead of REFERENCE+1.
- R8: On a match, output action 01 inverts `cmp_out`; action 10 drives `cmp_out` high for exactly one cycle.
- R9: The flag stays set until STATUS is written with bit0=1; writing STATUS with bit0=0 leaves it set.
- R10: `irq` is high exactly when the flag is set, CONFIG bit9=1 and CONFIG bit10=0; with bit10=1 an event raises `dma_req` and never `irq`.
- R11: `dma_req` stays high until a cycle with `dma_ack` high; that acknowledge drops `dma_req` and clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ext_clk_pin | input | 1 | External count source, asynchronous |
| cap_pin | input | 1 | Capture input, asynchronous |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request (level) |
| dma_req | output | 1 | DMA request, held until acknowledged |
| dma_ack | input | 1 | DMA acknowledge |

## Verification
The counting path is driven three ways. The first is the plain system clock with prescale 3, where the step period of 4 rules out an off-by-one in the N+1 division. The second is the divide-by-16 path with prescale 1, which separates a 32-cycle period from 16 or 2. The third is the external pin, both with and without prescaling, which shows that pin edges and not clock cycles are counted and that a stopped timer ignores them. Capture is tried with rising-only, falling-only and both-edge selects, each followed by the opposite edge, so that a wrong edge decode or a missing synchronizer stage shows up as a wrong latched value. Compare is tried with restart plus toggle, with no restart plus pulse, and with DMA steering, which separates the wrap value, the output shape and the irq/DMA routing.

// File: rtl/cct_pkg.sv
package cct_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int PSC_W  = 8;

    localparam logic [ADDR_W-1:0] A_CONFIG = 3'd0;
    localparam logic [ADDR_W-1:0] A_REF    = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAPT   = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_t;

    typedef enum logic [1:0] {
        OUT_LOW    = 2'b00,
        OUT_TOGGLE = 2'b01,
        OUT_PULSE  = 2'b10,
        OUT_SPARE  = 2'b11
    } out_act_t;

    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_CAPTURE = 2'd1,
        CH_COMPARE = 2'd2
    } ch_state_t;

    typedef enum logic {
        EV_IDLE     = 1'b0,
        EV_DMA_WAIT = 1'b1
    } ev_state_t;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             dma_en;
        logic             irq_en;
        out_act_t         out_act;
        logic             restart;
        edge_sel_t        edge_sel;
        logic             cmp_mode;
        logic             slow;
        logic             ext_src;
        logic             run;
    } cfg_t;

    function automatic cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
        cfg_t c;
        c.run      = w[0];
        c.ext_src  = w[1];
        c.slow     = w[2];
        c.cmp_mode = w[3];
        c.edge_sel = edge_sel_t'(w[5:4]);
        c.restart  = w[6];
        c.out_act  = out_act_t'(w[8:7]);
        c.irq_en   = w[9];
        c.dma_en   = w[10];
        c.psc      = w[16 +: PSC_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input cfg_t c);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[0]        = c.run;
        w[1]        = c.ext_src;
        w[2]        = c.slow;
        w[3]        = c.cmp_mode;
        w[5:4]      = c.edge_sel;
        w[6]        = c.restart;
        w[8:7]      = c.out_act;
        w[9]        = c.irq_en;
        w[10]       = c.dma_en;
        w[16 +: PSC_W] = c.psc;
        return w;
    endfunction

endpackage

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] shift_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            last_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], pin};
            last_q  <= shift_q[STAGES-1];
        end
    end

    assign rise = shift_q[STAGES-1] & ~last_q;
    assign fall = ~shift_q[STAGES-1] & last_q;

endmodule

// File: rtl/cct_tick_gen.sv
module cct_tick_gen #(
    parameter int PRE_DIV = 16,
    parameter int PSC_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_src,
    input  logic             slow,
    input  logic [PSC_W-1:0] psc,
    input  logic             ext_rise,
    output logic             cnt_tick
);

    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    logic             slow_tick;
    logic             src_tick;
    logic [PSC_W-1:0] ps_q;

    generate
        if (PRE_DIV > 1) begin : g_prediv
            logic [PRE_W-1:0] pre_q;
            logic             pre_wrap;

            assign pre_wrap = (pre_q == PRE_W'(PRE_DIV - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (!run || ext_src || !slow || pre_wrap) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end

            assign slow_tick = pre_wrap;
        end else begin : g_no_prediv
            assign slow_tick = 1'b1;
        end
    endgenerate

    always_comb begin
        if (!run) begin
            src_tick = 1'b0;
        end else if (ext_src) begin
            src_tick = ext_rise;
        end else if (slow) begin
            src_tick = slow_tick;
        end else begin
            src_tick = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (!run) begin
            ps_q <= '0;
        end else if (src_tick) begin
            if (ps_q >= psc) begin
                ps_q <= '0;
            end else begin
                ps_q <= ps_q + 1'b1;
            end
        end
    end

    assign cnt_tick = src_tick && (ps_q >= psc);

endmodule

// File: rtl/cct_channel.sv
module cct_channel
    import cct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cmp_mode,
    input  edge_sel_t        edge_sel,
    input  logic             restart,
    input  out_act_t         out_act,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             cnt_tick,
    input  logic             cap_rise,
    input  logic             cap_fall,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cap_val,
    output logic             cmp_hit,
    output logic             chan_ev,
    output logic             cmp_out
);

    ch_state_t        state_q;
    ch_state_t        state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic             out_q;
    logic             edge_hit;
    logic             cap_hit;
    logic             take_rise;
    logic             take_fall;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: OFF when stopped, otherwise the mode picks the state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (run) begin
                    state_d = cmp_mode ? CH_COMPARE : CH_CAPTURE;
                end
            end
            CH_CAPTURE: begin
                if (!run) begin
                    state_d = CH_OFF;
                end else if (cmp_mode) begin
                    state_d = CH_COMPARE;
                end
            end
            CH_COMPARE: begin
                if (!run) begin
                    state_d = CH_OFF;
                end else if (!cmp_mode) begin
                    state_d = CH_CAPTURE;
                end
            end
            default: state_d = CH_OFF;
        endcase
    end

    assign take_rise = (edge_sel == EDGE_RISE) || (edge_sel == EDGE_BOTH);
    assign take_fall = (edge_sel == EDGE_FALL) || (edge_sel == EDGE_BOTH);
    assign edge_hit  = (take_rise && cap_rise) || (take_fall && cap_fall);

    // Outputs of the state machine: which event the current state allows
    always_comb begin
        cap_hit = 1'b0;
        cmp_hit = 1'b0;
        unique case (state_q)
            CH_OFF:     ;
            CH_CAPTURE: cap_hit = edge_hit;
            CH_COMPARE: cmp_hit = cnt_tick && (cnt_q == ref_val);
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_load) begin
            cnt_q <= load_val;
        end else if (cnt_tick) begin
            if (cmp_hit && restart) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (cap_hit) begin
            cap_q <= cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            unique case (out_act)
                OUT_TOGGLE: out_q <= cmp_hit ? ~out_q : out_q;
                OUT_PULSE:  out_q <= cmp_hit;
                OUT_LOW,
                OUT_SPARE:  out_q <= 1'b0;
                default:    out_q <= 1'b0;
            endcase
        end
    end

    assign cnt_val = cnt_q;
    assign cap_val = cap_q;
    assign chan_ev = cap_hit | cmp_hit;
    assign cmp_out = out_q;

endmodule

// File: rtl/cct_event.sv
module cct_event
    import cct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chan_ev,
    input  logic irq_en,
    input  logic dma_en,
    input  logic flag_clr,
    input  logic dma_ack,
    output logic flag,
    output logic irq,
    output logic dma_req
);

    ev_state_t state_q;
    ev_state_t state_d;
    logic      flag_q;
    logic      ack_taken;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        ack_taken = 1'b0;
        unique case (state_q)
            EV_IDLE: begin
                if (chan_ev && dma_en) begin
                    state_d = EV_DMA_WAIT;
                end
            end
            EV_DMA_WAIT: begin
                ack_taken = dma_ack;
                if (dma_ack && !chan_ev) begin
                    state_d = EV_IDLE;
                end
            end
            default: state_d = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (chan_ev) begin
            flag_q <= 1'b1;
        end else if (flag_clr || ack_taken) begin
            flag_q <= 1'b0;
        end
    end

    assign flag    = flag_q;
    assign irq     = flag_q && irq_en && !dma_en;
    assign dma_req = (state_q == EV_DMA_WAIT);

endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PRE_DIV     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ext_clk_pin,
    input  logic              cap_pin,
    output logic              cmp_out,
    output logic              irq,
    output logic              dma_req,
    input  logic              dma_ack
);

    cfg_t             cfg_q;
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cap_val;
    logic             ext_rise;
    logic             ext_fall;
    logic             cap_rise;
    logic             cap_fall;
    logic             cnt_tick;
    logic             cnt_load;
    logic             stat_clr;
    logic             cmp_hit;
    logic             chan_ev;
    logic             flag;
    logic             cfg_run;
    logic             cfg_restart;
    logic             cfg_dma_en;
    logic             cfg_pulse;

    assign cnt_load    = bus_we && (bus_addr == A_COUNT);
    assign stat_clr    = bus_we && (bus_addr == A_STATUS) && bus_wdata[0];
    assign cfg_run     = cfg_q.run;
    assign cfg_restart = cfg_q.restart;
    assign cfg_dma_en  = cfg_q.dma_en;
    assign cfg_pulse   = (cfg_q.out_act == OUT_PULSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= cfg_from_word('0);
            ref_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_CONFIG) begin
                cfg_q <= cfg_from_word(bus_wdata);
            end
            if (bus_addr == A_REF) begin
                ref_q <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CONFIG: bus_rdata = cfg_to_word(cfg_q);
            A_REF:    bus_rdata[CNT_W-1:0] = ref_q;
            A_COUNT:  bus_rdata[CNT_W-1:0] = cnt_val;
            A_CAPT:   bus_rdata[CNT_W-1:0] = cap_val;
            A_STATUS: bus_rdata[0] = flag;
            default:  bus_rdata = '0;
        endcase
    end

    cct_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_clk_pin),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    cct_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cap_pin),
        .rise (cap_rise),
        .fall (cap_fall)
    );

    cct_tick_gen #(.PRE_DIV(PRE_DIV), .PSC_W(PSC_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg_q.run),
        .ext_src (cfg_q.ext_src),
        .slow    (cfg_q.slow),
        .psc     (cfg_q.psc),
        .ext_rise(ext_rise),
        .cnt_tick(cnt_tick)
    );

    cct_channel #(.CNT_W(CNT_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cfg_q.run),
        .cmp_mode(cfg_q.cmp_mode),
        .edge_sel(cfg_q.edge_sel),
        .restart (cfg_q.restart),
        .out_act (cfg_q.out_act),
        .ref_val (ref_q),
        .cnt_tick(cnt_tick),
        .cap_rise(cap_rise),
        .cap_fall(cap_fall),
        .cnt_load(cnt_load),
        .load_val(bus_wdata[CNT_W-1:0]),
        .cnt_val (cnt_val),
        .cap_val (cap_val),
        .cmp_hit (cmp_hit),
        .chan_ev (chan_ev),
        .cmp_out (cmp_out)
    );

    cct_event u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_ev (chan_ev),
        .irq_en  (cfg_q.irq_en),
        .dma_en  (cfg_q.dma_en),
        .flag_clr(stat_clr),
        .dma_ack (dma_ack),
        .flag    (flag),
        .irq     (irq),
        .dma_req (dma_req)
    );

endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             restart,
    input logic             dma_en,
    input logic             out_is_pulse,
    input logic             cnt_load,
    input logic             cmp_hit,
    input logic             chan_ev,
    input logic             stat_clr,
    input logic             dma_ack,
    input logic             flag,
    input logic             irq,
    input logic             dma_req,
    input logic             cmp_out,
    input logic [CNT_W-1:0] cnt_val
);

    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_load) |=> $stable(cnt_val));

    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && restart && !cnt_load) |=> (cnt_val == '0));

    assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_pulse && !cmp_hit) |=> !cmp_out);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_clr && !(dma_req && dma_ack)) |=> flag);

    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    assert_irq_steer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en |-> !irq);

    assert_dma_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req);

    assert_dma_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack && !chan_ev) |=> !dma_req);

endmodule

bind cct_timer cct_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (cfg_run),
    .restart     (cfg_restart),
    .dma_en      (cfg_dma_en),
    .out_is_pulse(cfg_pulse),
    .cnt_load    (cnt_load),
    .cmp_hit     (cmp_hit),
    .chan_ev     (chan_ev),
    .stat_clr    (stat_clr),
    .dma_ack     (dma_ack),
    .flag        (flag),
    .irq         (irq),
    .dma_req     (dma_req),
    .cmp_out     (cmp_out),
    .cnt_val     (cnt_val)
);

// File: tb/cct_timer_tb.sv
`timescale 1ns/1ps
module cct_timer_tb;

    localparam logic [2:0] A_CONFIG = 3'd0;
    localparam logic [2:0] A_REF    = 3'd1;
    localparam logic [2:0] A_COUNT  = 3'd2;
    localparam logic [2:0] A_CAPT   = 3'd3;
    localparam logic [2:0] A_STATUS = 3'd4;

    localparam logic [31:0] C_RUN   = 32'h1;
    localparam logic [31:0] C_EXT   = 32'h2;
    localparam logic [31:0] C_SLOW  = 32'h4;
    localparam logic [31:0] C_CMP   = 32'h8;
    localparam logic [31:0] C_RISE  = 32'h10;
    localparam logic [31:0] C_FALL  = 32'h20;
    localparam logic [31:0] C_BOTH  = 32'h30;
    localparam logic [31:0] C_RST   = 32'h40;
    localparam logic [31:0] C_TOG   = 32'h80;
    localparam logic [31:0] C_PUL   = 32'h100;
    localparam logic [31:0] C_IRQ   = 32'h200;
    localparam logic [31:0] C_DMA   = 32'h400;

    localparam int K_REG = 0;
    localparam int K_IRQ = 1;
    localparam int K_DMA = 2;
    localparam int K_OUT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [2:0]  rd_addr = '0;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_clk_pin = 1'b0;
    logic        cap_pin = 1'b0;
    logic        cmp_out;
    logic        irq;
    logic        dma_req;
    logic        dma_ack = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;
        logic [2:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];

    always #10 clk = ~clk;

    assign bus_addr = bus_we ? wr_addr : rd_addr;

    cct_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ext_clk_pin(ext_clk_pin),
        .cap_pin    (cap_pin),
        .cmp_out    (cmp_out),
        .irq        (irq),
        .dma_req    (dma_req),
        .dma_ack    (dma_ack)
    );

    // Monitor: pops each expected item and compares with what the DUT shows
    initial begin
        forever begin
            item_t it;
            logic [31:0] obs;
            wait (sbq.size() > 0);
            it = sbq.pop_front();
            rd_addr = it.addr;
            #1;
            case (it.kind)
                K_IRQ:   obs = {31'b0, irq};
                K_DMA:   obs = {31'b0, dma_req};
                K_OUT:   obs = {31'b0, cmp_out};
                default: obs = bus_rdata;
            endcase
            n_checks++;
            if (obs !== it.exp) begin
                n_errors++;
                $display("FAIL %s: actual=%0d expected=%0d", it.tag, obs, it.exp);
            end
        end
    end

    // Driver side: push one expected item and wait until it has been compared
    task automatic expect_item(input int kind, input logic [2:0] a,
                               input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind;
        it.addr = a;
        it.exp  = e;
        it.tag  = tag;
        sbq.push_back(it);
        wait (sbq.size() == 0);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_addr   = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_pin = 1'b1;
            idle(2);
            ext_clk_pin = 1'b0;
            idle(2);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        expect_item(K_REG, A_COUNT, 0, "R1 count after reset");
        expect_item(K_REG, A_CAPT, 0, "R1 captured after reset");
        expect_item(K_REG, A_STATUS, 0, "R1 status after reset");
        idle(1);
        expect_item(K_IRQ, 0, 0, "R1 irq after reset");
        expect_item(K_DMA, 0, 0, "R1 dma_req after reset");
        expect_item(K_OUT, 0, 0, "R1 cmp_out after reset");
        idle(1);

        // R2: system clock, prescale 3 -> one step per 4 cycles
        wr(A_COUNT, 0);
        wr(A_CONFIG, C_RUN | (32'd3 << 16));
        expect_item(K_REG, A_COUNT, 0, "R2 count at start");
        idle(8);
        expect_item(K_REG, A_COUNT, 2, "R2 count after 8 cycles");
        idle(3);
        expect_item(K_REG, A_COUNT, 2, "R2 count after 11 cycles");
        idle(1);
        expect_item(K_REG, A_COUNT, 3, "R2 count after 12 cycles");

        // R5: stop freezes, write loads
        wr(A_CONFIG, 0);
        idle(10);
        expect_item(K_REG, A_COUNT, 3, "R5 count frozen while stopped");
        wr(A_COUNT, 100);
        expect_item(K_REG, A_COUNT, 100, "R5 count load");

        // R3: divide by 16, prescale 1 -> one step per 32 cycles
        wr(A_COUNT, 0);
        wr(A_CONFIG, C_RUN | C_SLOW | (32'd1 << 16));
        idle(31);
        expect_item(K_REG, A_COUNT, 0, "R3 count after 31 cycles");
        idle(1);
        expect_item(K_REG, A_COUNT, 1, "R3 count after 32 cycles");
        idle(32);
        expect_item(K_REG, A_COUNT, 2, "R3 count after 64 cycles");
        wr(A_CONFIG, 0);

        // R4: external clock edges
        wr(A_COUNT, 0);
        wr(A_CONFIG, C_RUN | C_EXT);
        ext_pulses(5);
        idle(4);
        expect_item(K_REG, A_COUNT, 5, "R4 five external edges");
        wr(A_CONFIG, C_EXT);
        ext_pulses(3);
        idle(4);
        expect_item(K_REG, A_COUNT, 5, "R4 edges ignored while stopped");
        wr(A_COUNT, 0);
        wr(A_CONFIG, C_RUN | C_EXT | (32'd1 << 16));
        ext_pulses(6);
        idle(4);
        expect_item(K_REG, A_COUNT, 3, "R4 six edges with prescale 1");
        wr(A_CONFIG, 0);

        // R6: rising-edge capture
        wr(A_COUNT, 0);
        wr(A_CONFIG, C_RUN | C_RISE);
        idle(10);
        cap_pin = 1'b1;
        idle(3);
        expect_item(K_REG, A_CAPT, 12, "R6 rising capture value");
        expect_item(K_REG, A_STATUS, 1, "R6 flag set by capture");
        expect_item(K_IRQ, 0, 0, "R10 irq low with irq disabled");
        wr(A_STATUS, 0);
        expect_item(K_REG, A_STATUS, 1, "R9 write zero keeps flag");
        wr(A_STATUS, 1);
        expect_item(K_REG, A_STATUS, 0, "R9 write one clears flag");
        cap_pin = 1'b0;
        idle(4);
        expect_item(K_REG, A_STATUS, 0, "R6 falling edge ignored (flag)");
        expect_item(K_REG, A_CAPT, 12, "R6 falling edge ignored (value)");

        // R6: falling-edge capture with irq enabled
        wr(A_CONFIG, C_RUN | C_FALL | C_IRQ);
        wr(A_COUNT, 0);
        idle(5);
        cap_pin = 1'b1;
        idle(4);
        expect_item(K_REG, A_STATUS, 0, "R6 rising edge ignored in falling mode");
        cap_pin = 1'b0;
        idle(3);
        expect_item(K_REG, A_CAPT, 11, "R6 falling capture value");
        expect_item(K_IRQ, 0, 1, "R10 irq raised with irq enabled");

        // R6: both edges
        wr(A_CONFIG, C_RUN | C_BOTH);
        wr(A_COUNT, 0);
        idle(4);
        cap_pin = 1'b1;
        idle(3);
        expect_item(K_REG, A_CAPT, 6, "R6 both-edge capture on rise");
        cap_pin = 1'b0;
        idle(3);
        expect_item(K_REG, A_CAPT, 9, "R6 both-edge capture on fall");

        // R7/R8: compare with restart and toggle
        wr(A_CONFIG, 0);
        wr(A_STATUS, 1);
        wr(A_REF, 5);
        wr(A_COUNT, 0);
        wr(A_CONFIG, C_RUN | C_CMP | C_RST | C_TOG | C_IRQ);
        idle(5);
        expect_item(K_REG, A_COUNT, 5, "R7 count reaches reference");
        expect_item(K_IRQ, 0, 0, "R7 no event before match step");
        idle(1);
        expect_item(K_REG, A_COUNT, 0, "R7 restart to zero");
        expect_item(K_IRQ, 0, 1, "R7 match raises irq");
        expect_item(K_OUT, 0, 1, "R8 toggle high on first match");
        wr(A_STATUS, 1);
        expect_item(K_REG, A_STATUS, 0, "R9 clear after match");
        idle(4);
        expect_item(K_OUT, 0, 1, "R8 toggle holds between matches");
        idle(1);
        expect_item(K_OUT, 0, 0, "R8 toggle low on second match");
        expect_item(K_REG, A_STATUS, 1, "R7 second match sets flag");

        // R7/R8: compare without restart, pulse output
        wr(A_CONFIG, 0);
        wr(A_STATUS, 1);
        wr(A_COUNT, 0);
        wr(A_REF, 3);
        wr(A_CONFIG, C_RUN | C_CMP | C_PUL);
        idle(3);
        expect_item(K_OUT, 0, 0, "R8 pulse low before match");
        idle(1);
        expect_item(K_REG, A_COUNT, 4, "R7 no restart continues past reference");
        expect_item(K_OUT, 0, 1, "R8 pulse high after match");
        idle(1);
        expect_item(K_OUT, 0, 0, "R8 pulse lasts one cycle");

        // R10/R11: DMA steering
        wr(A_CONFIG, 0);
        wr(A_STATUS, 1);
        wr(A_COUNT, 0);
        wr(A_REF, 4);
        wr(A_CONFIG, C_RUN | C_CMP | C_IRQ | C_DMA);
        idle(4);
        expect_item(K_DMA, 0, 0, "R11 no request before match");
        idle(1);
        expect_item(K_DMA, 0, 1, "R10 match raises dma_req");
        expect_item(K_IRQ, 0, 0, "R10 irq suppressed by dma steering");
        idle(5);
        expect_item(K_DMA, 0, 1, "R11 request held without ack");
        dma_ack = 1'b1;
        idle(1);
        dma_ack = 1'b0;
        expect_item(K_DMA, 0, 0, "R11 ack drops request");
        expect_item(K_REG, A_STATUS, 0, "R11 ack clears flag");

        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule